// File: doc/BRIEF.md
# UART with Loopback Self-Test

This block is an 8-bit asynchronous serial transceiver with a built-in go/no-go self-test. The host loads bytes into a small transmit queue. The transmitter frames each byte and shifts it out on `ser_out`. The receiver watches `ser_in`, recovers the bytes and queues them for the host. Bit timing comes from a free-running tick divider with 16 sample ticks per bit. The default divider of 326 turns a 50 MHz clock into a rate of about 9600 bit/s. Each received frame is checked, and any problem latches into a three-bit status register. That register keeps its bits until the host clears it.

A pulse on `bist_start` switches the block into self-test mode. In this mode an on-chip 8-bit maximal-length shift-register generator takes the place of the host as the byte source. The transmit line is fed straight back into the receiver, and `ser_in` is ignored. Every one of the 255 non-zero patterns is framed, sent, received and compared against a second copy of the same generator. When the last byte has been compared, the block raises `bist_done`. `bist_pass` tells whether every byte matched and no frame error appeared. The transmit line stays visible on `ser_out` during the run, so a tester can watch it.

Top module: `uart_selftest`

## Requirements
- R1: Every frame on `ser_out` is: one start bit at 0, then 8 data bits with the least significant bit first, then one parity bit, then one stop bit at 1. Each bit lasts OVS*CLK_DIV clocks. The line is 1 while idle and after reset.
- R2: The parity bit makes the number of ones across the data and parity bits odd when `parity_odd`=1, and even when `parity_odd`=0. The transmitter and the receiver both use this rule.
- R3: A falling edge on the idle receive line starts a frame. Each bit is sampled at the 8th tick of its 16. The recovered byte enters a FIFO of FIFO_DEPTH entries. `rx_valid`/`rx_data` show the oldest entry, and `rx_read` removes it.
- R4: If the start bit reads 1 at its middle sample, it is treated as a glitch. The glitch stores no byte and sets no status bit.
- R5: `stat_flags` bit 0 flags a parity mismatch. Bit 1 flags a framing error, which is a stop bit sampled as 0. Bit 2 flags an overrun, which is a frame that completes while the receive FIFO is full; that byte is dropped. A flagged frame that is not an overrun is still stored. Each bit stays set until a `stat_read` pulse clears it on the next clock edge.
- R6: A `bist_start` pulse while idle raises `bist_busy` at the next clock edge. The same edge clears `bist_done` and `bist_pass` and empties both FIFOs. While busy, the receiver is fed from the transmit line, `ser_in` is ignored, and `ser_out` keeps carrying the transmit line. After the run the receiver again listens to `ser_in`.
- R7: The self-test bytes start at 0x01. Each next byte is `{q[6:0], q[7]^q[5]^q[4]^q[3]}`, which follows the polynomial x^8+x^6+x^5+x^4+1. The run sends 255 bytes, all different and none zero.
- R8: After the 255th byte has been compared, `bist_busy` falls and `bist_done` rises. `bist_pass`=1 only if every received byte equalled its expected value and no parity, framing or overrun event happened during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| host_wr | input | 1 | Host write strobe into the transmit FIFO; ignored when the FIFO is full or a self-test is running |
| host_wdata | input | 8 | Host byte to transmit |
| host_full | output | 1 | Transmit FIFO is full |
| rx_valid | output | 1 | Receive FIFO holds a byte for the host |
| rx_data | output | 8 | Oldest received byte |
| rx_read | input | 1 | Host removes the oldest received byte |
| ser_in | input | 1 | External serial receive line |
| ser_out | output | 1 | Serial transmit line |
| stat_read | input | 1 | Host read of the status register; clears the sticky bits |
| stat_flags | output | 3 | {overrun, framing error, parity error} |
| bist_start | input | 1 | Start strobe of the self-test control |
| bist_busy | output | 1 | Self-test in progress |
| bist_done | output | 1 | Self-test finished |
| bist_pass | output | 1 | Result of the last finished self-test |

## Verification
A wrong generator state shows up on `ser_out` within one frame of the run, because the bench decodes all 255 frames and compares them with its own model of the sequence. A receiver that samples at the wrong tick, or tracks the wrong state, either corrupts the byte returned at `rx_data` at the end of that frame or misses a glitch. A stuck or lost status bit shows at `stat_flags` on the cycle after the bad frame's stop sample. A comparator or pass-tracking fault stays hidden until `bist_done`. The bench therefore forces a parity fault in the middle of a run and requires `bist_pass` to stay low.

// File: rtl/uart_st_pkg.sv
package uart_st_pkg;

  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] LFSR_SEED = 8'h01;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

  typedef struct packed {
    logic overrun;
    logic framing;
    logic parity;
  } stat_t;

  // x^8 + x^6 + x^5 + x^4 + 1, shift toward the MSB
  function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

endpackage

// File: rtl/uart_st_fifo.sv
module uart_st_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (wr_en) wptr_d = wptr_q + 1'b1;
      if (rd_en) rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem_q[wptr_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem_q[rptr_q[AW-1:0]];
  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);  // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty); // R3

endmodule

// File: rtl/uart_st_tx.sv
module uart_st_tx
  import uart_st_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              odd_par,
  input  logic              avail,
  input  logic [DATA_W-1:0] din,
  output logic              pop,
  output logic              line
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(DATA_W);

  tx_state_t       state_q, state_d;
  logic [CW-1:0]   tcnt_q, tcnt_d;
  logic [BW-1:0]   bcnt_q, bcnt_d;
  logic [DATA_W:0] shift_q, shift_d;
  logic            bit_end;

  assign bit_end = tick && (tcnt_q == CW'(OVS - 1));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    shift_d = shift_q;
    pop     = 1'b0;
    line    = 1'b1;
    if (state_q != TX_IDLE && tick) tcnt_d = bit_end ? '0 : tcnt_q + 1'b1;
    case (state_q)
      TX_IDLE: begin
        if (avail) begin
          pop     = 1'b1;
          shift_d = {(^din) ^ odd_par, din};
          tcnt_d  = '0;
          state_d = TX_START;
        end
      end
      TX_START: begin
        line = 1'b0;
        if (bit_end) begin
          bcnt_d  = '0;
          state_d = TX_DATA;
        end
      end
      TX_DATA: begin
        line = shift_q[0];
        if (bit_end) begin
          shift_d = shift_q >> 1;
          if (bcnt_q == BW'(DATA_W - 1)) state_d = TX_PAR;
          else                           bcnt_d  = bcnt_q + 1'b1;
        end
      end
      TX_PAR: begin
        line = shift_q[0];
        if (bit_end) state_d = TX_STOP;
      end
      TX_STOP: begin
        if (bit_end) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shift_q <= shift_d;
    end
  end

  AST_TX_PAR_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_PAR && bit_end) |=> (state_q == TX_STOP && line)); // R1

endmodule

// File: rtl/uart_st_rx.sv
module uart_st_rx
  import uart_st_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic              odd_par,
  input  logic              line_in,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_out,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW  = $clog2(DATA_W);
  localparam int MID = OVS / 2 - 1;

  rx_state_t         state_q, state_d;
  logic [CW-1:0]     tcnt_q, tcnt_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              par_q, par_d;
  logic              s1_q, s2_q, s3_q;
  logic              fall, mid, last;

  assign fall     = s3_q && !s2_q;
  assign mid      = tick && (tcnt_q == CW'(MID));
  assign last     = tick && (tcnt_q == CW'(OVS - 1));
  assign byte_out = shift_q;

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    bcnt_d   = bcnt_q;
    shift_d  = shift_q;
    par_d    = par_q;
    byte_vld = 1'b0;
    par_err  = 1'b0;
    frm_err  = 1'b0;
    if (state_q != RX_IDLE && tick) tcnt_d = last ? '0 : tcnt_q + 1'b1;
    case (state_q)
      RX_IDLE: begin
        if (fall) begin
          tcnt_d  = '0;
          state_d = RX_START;
        end
      end
      RX_START: begin
        if (mid && s2_q) state_d = RX_IDLE;
        else if (last) begin
          bcnt_d  = '0;
          state_d = RX_DATA;
        end
      end
      RX_DATA: begin
        if (mid) shift_d = {s2_q, shift_q[DATA_W-1:1]};
        if (last) begin
          if (bcnt_q == BW'(DATA_W - 1)) state_d = RX_PAR;
          else                           bcnt_d  = bcnt_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (mid)  par_d   = s2_q;
        if (last) state_d = RX_STOP;
      end
      RX_STOP: begin
        if (mid) begin
          byte_vld = 1'b1;
          par_err  = ((^shift_q) ^ par_q) != odd_par;
          frm_err  = !s2_q;
          state_d  = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
    if (clr) state_d = RX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      s3_q    <= 1'b1;
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
    end else begin
      s1_q    <= line_in;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shift_q <= shift_d;
      par_q   <= par_d;
    end
  end

  AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R3
  AST_RX_GLITCH_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && mid && s2_q) |=> (state_q == RX_IDLE && !byte_vld)); // R4

endmodule

// File: rtl/uart_st_bist.sv
module uart_st_bist
  import uart_st_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              err_evt,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              pop,
  output logic              clr,
  output logic              busy,
  output logic              done,
  output logic              pass
);
  localparam int TEST_LEN = (1 << DATA_W) - 1;
  localparam logic [DATA_W-1:0] LAST = DATA_W'(TEST_LEN);

  logic              busy_q, busy_d, done_q, done_d, pass_q, pass_d, ok_q, ok_d;
  logic [DATA_W-1:0] gen_q, gen_d, exp_q, exp_d;
  logic [DATA_W-1:0] pcnt_q, pcnt_d, ccnt_q, ccnt_d;
  logic              accept;

  assign accept    = start && !busy_q;
  assign clr       = accept;
  assign push      = busy_q && (pcnt_q != LAST) && !tx_full;
  assign push_data = gen_q;
  assign pop       = busy_q && !rx_empty;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    pass_d = pass_q;
    ok_d   = ok_q;
    gen_d  = gen_q;
    exp_d  = exp_q;
    pcnt_d = pcnt_q;
    ccnt_d = ccnt_q;
    if (accept) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      pass_d = 1'b0;
      ok_d   = 1'b1;
      gen_d  = LFSR_SEED;
      exp_d  = LFSR_SEED;
      pcnt_d = '0;
      ccnt_d = '0;
    end else if (busy_q) begin
      if (push) begin
        gen_d  = lfsr_step(gen_q);
        pcnt_d = pcnt_q + 1'b1;
      end
      if (err_evt || (pop && rx_data != exp_q)) ok_d = 1'b0;
      if (pop) begin
        exp_d  = lfsr_step(exp_q);
        ccnt_d = ccnt_q + 1'b1;
        if (ccnt_q == LAST - 1'b1) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          pass_d = ok_d;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      ok_q   <= 1'b0;
      gen_q  <= LFSR_SEED;
      exp_q  <= LFSR_SEED;
      pcnt_q <= '0;
      ccnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pass_q <= pass_d;
      ok_q   <= ok_d;
      gen_q  <= gen_d;
      exp_q  <= exp_d;
      pcnt_q <= pcnt_d;
      ccnt_q <= ccnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign pass = pass_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (gen_q != '0 && exp_q != '0)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && !done_q)); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R8
  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> done_q); // R8

endmodule

// File: rtl/uart_selftest.sv
module uart_selftest
  import uart_st_pkg::*;
#(
  parameter int CLK_DIV    = 326,
  parameter int OVS        = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              parity_odd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_full,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_read,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              stat_read,
  output logic [2:0]        stat_flags,
  input  logic              bist_start,
  output logic              bist_busy,
  output logic              bist_done,
  output logic              bist_pass
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_i_n <= rst_m_q;
    end
  end

  // sample tick divider
  logic [DW-1:0] div_q, div_d;
  logic          tick;
  assign tick  = (div_q == DW'(CLK_DIV - 1));
  assign div_d = tick ? '0 : div_q + 1'b1;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) div_q <= '0;
    else          div_q <= div_d;
  end

  logic              tx_full, tx_empty, tx_pop, tx_push, tx_line;
  logic [DATA_W-1:0] tx_wdata, tx_head;
  logic              rx_full, rx_empty, rx_wr, rx_rd, rx_line;
  logic              byte_vld, par_err, frm_err, ovr_evt, err_evt;
  logic [DATA_W-1:0] rx_byte, rx_head;
  logic              b_push, b_pop, b_clr;
  logic [DATA_W-1:0] b_data;

  assign tx_push  = bist_busy ? b_push : (host_wr && !tx_full);
  assign tx_wdata = bist_busy ? b_data : host_wdata;
  assign rx_line  = bist_busy ? tx_line : ser_in;
  assign rx_wr    = byte_vld && !rx_full;
  assign ovr_evt  = byte_vld && rx_full;
  assign err_evt  = par_err || frm_err || ovr_evt;
  assign rx_rd    = bist_busy ? b_pop : (rx_read && !rx_empty);

  uart_st_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_i_n), .clr(b_clr),
    .wr_en(tx_push), .wr_data(tx_wdata),
    .rd_en(tx_pop), .rd_data(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  uart_st_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .odd_par(parity_odd),
    .avail(!tx_empty), .din(tx_head), .pop(tx_pop), .line(tx_line)
  );

  uart_st_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .clr(b_clr), .odd_par(parity_odd),
    .line_in(rx_line), .byte_vld(byte_vld), .byte_out(rx_byte),
    .par_err(par_err), .frm_err(frm_err)
  );

  uart_st_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_i_n), .clr(b_clr),
    .wr_en(rx_wr), .wr_data(rx_byte),
    .rd_en(rx_rd), .rd_data(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  uart_st_bist u_bist (
    .clk(clk), .rst_n(rst_i_n), .start(bist_start),
    .tx_full(tx_full), .rx_empty(rx_empty), .rx_data(rx_head), .err_evt(err_evt),
    .push(b_push), .push_data(b_data), .pop(b_pop), .clr(b_clr),
    .busy(bist_busy), .done(bist_done), .pass(bist_pass)
  );

  // sticky status register
  stat_t stat_q, stat_d;
  always_comb begin
    stat_d = stat_read ? '0 : stat_q;
    if (par_err) stat_d.parity  = 1'b1;
    if (frm_err) stat_d.framing = 1'b1;
    if (ovr_evt) stat_d.overrun = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) stat_q <= '0;
    else          stat_q <= stat_d;
  end

  assign stat_flags = stat_q;
  assign host_full  = tx_full;
  assign rx_valid   = !rx_empty && !bist_busy;
  assign rx_data    = rx_head;
  assign ser_out    = tx_line;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    !stat_read |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5
  AST_LOOPBACK_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bist_busy && $past(bist_busy) && $stable(tx_line) && !$stable(ser_in)) |-> $stable(rx_line)); // R6

endmodule

// File: tb/uart_selftest_tb.sv
module uart_selftest_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 1;
  localparam int OVS   = 16;
  localparam int DEPTH = 4;
  localparam int BIT   = DIV * OVS;
  localparam int WD    = 150000;

  logic       clk, rst_n, parity_odd, host_wr, host_full, rx_valid, rx_read;
  logic       ser_in, ser_out, stat_read, bist_start, bist_busy, bist_done, bist_pass;
  logic [7:0] host_wdata, rx_data;
  logic [2:0] stat_flags;

  int n_chk  = 0;
  int n_fail = 0;

  uart_selftest #(.CLK_DIV(DIV), .OVS(OVS), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .parity_odd(parity_odd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_full(host_full),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_read(rx_read),
    .ser_in(ser_in), .ser_out(ser_out), .stat_read(stat_read), .stat_flags(stat_flags),
    .bist_start(bist_start), .bist_busy(bist_busy), .bist_done(bist_done), .bist_pass(bist_pass)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_next(input logic [7:0] q);
    logic fb;
    fb = q[7] ^ q[5] ^ q[4] ^ q[3];
    return (q << 1) | {7'd0, fb};
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic par, input logic stop);
    logic [10:0] bits;
    bits = {stop, par, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      ser_in = bits[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk);
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic grab_frame(output logic [7:0] d, output logic p, output logic s, output logic st);
    while (ser_out !== 1'b0) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    st = ser_out;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = ser_out;
    end
    repeat (BIT) @(negedge clk);
    p = ser_out;
    repeat (BIT) @(negedge clk);
    s = ser_out;
  endtask

  task automatic host_send(input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk);
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk);
    stat_read = 1'b1;
    @(negedge clk);
    stat_read = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};

  initial begin
    logic [7:0] d;
    logic p, s, st;
    int waitc;

    rst_n = 1'b0; parity_odd = 1'b0; host_wr = 1'b0; host_wdata = '0;
    rx_read = 1'b0; ser_in = 1'b1; stat_read = 1'b0; bist_start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk(ser_out == 1'b1, "R1 idle line", ser_out, 1);
    chk(rx_valid == 1'b0, "R3 rx empty after reset", rx_valid, 0);
    chk(stat_flags == 3'b000, "R5 flags after reset", stat_flags, 0);
    chk(bist_busy == 1'b0 && bist_done == 1'b0 && bist_pass == 1'b0, "R8 bist idle after reset",
        {bist_busy, bist_done, bist_pass}, 0);

    // transmit sweep: frame layout and parity in both modes (R1, R2)
    for (int m = 0; m < 2; m++) begin
      parity_odd = m[0];
      foreach (pats[k]) begin
        fork
          grab_frame(d, p, s, st);
          host_send(pats[k]);
        join
        chk(st == 1'b0, "R1 start bit", st, 0);
        chk(d == pats[k], "R1 data LSB first", d, pats[k]);
        chk(p == ((^pats[k]) ^ m[0]), "R2 tx parity", p, (^pats[k]) ^ m[0]);
        chk(s == 1'b1, "R1 stop bit", s, 1);
      end
    end

    // receive sweep (R3, R2)
    for (int m = 0; m < 2; m++) begin
      parity_odd = m[0];
      foreach (pats[k]) begin
        send_frame(pats[k], (^pats[k]) ^ m[0], 1'b1);
        chk(rx_valid == 1'b1, "R3 byte arrived", rx_valid, 1);
        chk(rx_data == pats[k], "R3 rx data", rx_data, pats[k]);
        chk(stat_flags == 3'b000, "R2 rx parity accepted", stat_flags, 0);
        pulse_read();
        chk(rx_valid == 1'b0, "R3 read pops", rx_valid, 0);
      end
    end
    parity_odd = 1'b0;

    // parity error, sticky until read (R5)
    send_frame(8'h5A, ~(^8'h5A), 1'b1);
    chk(stat_flags == 3'b001, "R5 parity flag", stat_flags, 1);
    chk(rx_valid == 1'b1 && rx_data == 8'h5A, "R5 flagged byte kept", rx_data, 8'h5A);
    pulse_read();
    repeat (50) @(negedge clk);
    chk(stat_flags == 3'b001, "R5 flag sticky", stat_flags, 1);
    clear_status();
    chk(stat_flags == 3'b000, "R5 read clears", stat_flags, 0);

    // framing error (R5)
    send_frame(8'hC3, ^8'hC3, 1'b0);
    chk(stat_flags == 3'b010, "R5 framing flag", stat_flags, 2);
    pulse_read();
    clear_status();

    // glitch shorter than half a bit (R4)
    @(negedge clk);
    ser_in = 1'b0;
    repeat (BIT / 2 - 2) @(negedge clk);
    ser_in = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    chk(rx_valid == 1'b0, "R4 glitch stores nothing", rx_valid, 0);
    chk(stat_flags == 3'b000, "R4 glitch flags nothing", stat_flags, 0);

    // overrun (R5)
    for (int i = 0; i <= DEPTH; i++) send_frame(8'h10 + 8'(i), ^(8'h10 + 8'(i)), 1'b1);
    chk(stat_flags == 3'b100, "R5 overrun flag", stat_flags, 4);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rx_valid == 1'b1 && rx_data == 8'h10 + 8'(i), "R5 kept bytes in order", rx_data, 8'h10 + i);
      pulse_read();
    end
    chk(rx_valid == 1'b0, "R5 extra byte dropped", rx_valid, 0);
    clear_status();

    // self-test with ser_in held low: must be ignored (R6, R7, R8)
    begin
      logic [255:0] seen;
      int n_ok, n_new;
      logic [7:0] m8;
      seen = '0; n_ok = 0; n_new = 0; m8 = 8'h01;
      fork
        begin
          for (int k = 0; k < 255; k++) begin
            grab_frame(d, p, s, st);
            if (d == m8 && p == (^d) && s == 1'b1 && st == 1'b0) n_ok++;
            if (d != 8'h00 && !seen[d]) n_new++;
            seen[d] = 1'b1;
            m8 = model_next(m8);
            if (k == 100) ser_in = 1'b1;
          end
        end
        begin
          @(negedge clk);
          bist_start = 1'b1;
          ser_in = 1'b0;
          @(negedge clk);
          bist_start = 1'b0;
          chk(bist_busy == 1'b1 && bist_done == 1'b0, "R6 start raises busy", bist_busy, 1);
          waitc = 0;
          while (!bist_done && waitc < 60000) begin
            @(negedge clk);
            waitc++;
          end
        end
      join
      chk(n_ok == 255, "R7 sequence on ser_out", n_ok, 255);
      chk(n_new == 255, "R7 distinct non-zero bytes", n_new, 255);
    end
    chk(bist_done == 1'b1 && bist_busy == 1'b0, "R8 done after run", bist_done, 1);
    chk(bist_pass == 1'b1, "R8 pass with pin ignored (R6)", bist_pass, 1);
    chk(stat_flags == 3'b000, "R8 no errors in clean run", stat_flags, 0);
    chk(rx_valid == 1'b0, "R6 receive queue drained", rx_valid, 0);

    // self-test with a parity fault injected mid run (R8)
    @(negedge clk);
    bist_start = 1'b1;
    @(negedge clk);
    bist_start = 1'b0;
    chk(bist_done == 1'b0 && bist_pass == 1'b0, "R6 start clears result", {bist_done, bist_pass}, 0);
    repeat (3000) @(negedge clk);
    parity_odd = 1'b1;
    waitc = 0;
    while (!bist_done && waitc < 60000) begin
      @(negedge clk);
      waitc++;
    end
    chk(bist_done == 1'b1, "R8 faulty run finishes", bist_done, 1);
    chk(bist_pass == 1'b0, "R8 fault gives no pass", bist_pass, 0);
    chk(stat_flags[0] == 1'b1, "R5 parity flag from run", stat_flags, 1);
    clear_status();

    // receiver listens to the pin again (R6)
    send_frame(8'h96, ~(^8'h96), 1'b1);
    chk(rx_valid == 1'b1 && rx_data == 8'h96, "R6 pin path restored", rx_data, 8'h96);
    chk(stat_flags == 3'b000, "R2 odd parity accepted", stat_flags, 0);

    finish_run();
  end

endmodule